// File: doc/BRIEF.md
# Half-duplex SPI command engine

This block is a memory-mapped SPI master that runs one flash-style command each time software triggers it. Software writes an opcode byte and a transmit and a receive byte count. It picks one of four active-low chip selects and fills a byte-addressed data buffer with the outgoing bytes. It then sets the execute bit. The engine asserts the selected chip select and shifts out the opcode, then the transmit bytes. It then clocks in the requested number of receive bytes and releases the chip select. Received bytes go into the same buffer, directly after the transmit bytes.

An internal buffer pointer gives the base of each command. The pointer advances over every buffer byte the command uses, and software resets it to zero with a clear bit. The clear bit may share one write with the execute bit. A busy flag is set from the cycle after the trigger until the command has completed. The engine works in SPI mode 0, most significant bit first, with the serial clock derived from the system clock by a fixed even divider.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, the busy bit is 0, all chip-select outputs are high, the serial clock and data-out are low, and the opcode, count and chip-select registers read 0.
- R2: A command frame carries the opcode byte first and then the transmit bytes, taken from buffer index base+0 upward. Bytes go out most significant bit first in mode 0: the clock idles low, data-out changes only while the clock is low, and each bit lasts DIV system cycles.
- R3: During the receive phase data-out is held at 0. Data-in is sampled on each rising clock edge, and received byte i is stored at buffer index base+txcount+i, where it reads back at address 0x80 plus that index.
- R4: Bits 1:0 of the byte at address 0x1D pick chip-select line n. Line n goes low in the cycle after the execute write and stays low through the last byte, while the other lines stay high. All lines are high once the command completes, and at most one line is ever low.
- R5: Bit 7 of the byte at address 0x03 reads 1 from the cycle after the execute write until the command has completed, and 0 otherwise.
- R6: Writing 1 to bit 0 of the byte at address 0x02 starts a command only when the engine is idle. Such a write while busy produces no second frame and does not change the running frame.
- R7: Writing 1 to bit 4 of the byte at address 0x02 while idle resets the buffer pointer (base) to 0. Without it, the next command's base is the index just past the last byte that the previous command used.
- R8: The transmit count is clamped to DEPTH-base, and the receive count is clamped to the space left after it. No frame byte ever addresses past the end of the buffer.
- R9: The opcode (address 0x00), transmit count (0x48), receive count (0x4B), chip-select field (0x1D) and buffer bytes (0x80+i) read back the values written.
- R10: With both counts zero, or with no room left, the frame consists of the opcode byte alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register/buffer byte address |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
An execute write registers on the next rising edge. Busy and the selected chip select are therefore read at the falling edge that follows the write, one cycle later. Each serial byte then takes 8*DIV system cycles, with one extra idle-low cycle between bytes. Rather than counting cycles to the end of a frame, the bench captures data-out on every rising serial-clock edge and compares each completed byte with the next entry in its queue of expected bytes. Buffer read-back and the final chip-select state are checked only after the busy bit reads 0, and all register reads are sampled just after a falling system-clock edge.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_TX,
    ST_RX,
    ST_FIN
  } seq_state_t;

  localparam logic [7:0] A_OPC  = 8'h00;
  localparam logic [7:0] A_CMD  = 8'h02;
  localparam logic [7:0] A_STAT = 8'h03;
  localparam logic [7:0] A_CSEL = 8'h1D;
  localparam logic [7:0] A_TXN  = 8'h48;
  localparam logic [7:0] A_RXN  = 8'h4B;
  localparam logic [7:0] A_BUF  = 8'h80;

  localparam int CMD_EXEC_BIT = 0;
  localparam int CMD_CLR_BIT  = 4;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int NCS   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CSW  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     reg_addr,
  input  logic           reg_wr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           busy,
  input  logic [7:0]     buf_rdata,
  output logic [AW-1:0]  buf_addr,
  output logic           buf_we,
  output logic [7:0]     opc_q,
  output logic [CSW-1:0] csel_q,
  output logic [7:0]     txn_q,
  output logic [7:0]     rxn_q,
  output logic           exec_req,
  output logic           clr_req
);

  logic [7:0]     opc_d, txn_d, rxn_d;
  logic [CSW-1:0] csel_d;
  logic [7:0]     boff;
  logic           in_buf;
  logic           cmd_wr;

  assign boff     = reg_addr - A_BUF;
  assign in_buf   = (reg_addr >= A_BUF) && (32'(boff) < DEPTH);
  assign buf_addr = AW'(boff);
  assign buf_we   = reg_wr && in_buf && !busy;
  assign cmd_wr   = reg_wr && (reg_addr == A_CMD) && !busy;
  assign exec_req = cmd_wr && reg_wdata[CMD_EXEC_BIT];
  assign clr_req  = cmd_wr && reg_wdata[CMD_CLR_BIT];

  always_comb begin
    opc_d  = opc_q;
    txn_d  = txn_q;
    rxn_d  = rxn_q;
    csel_d = csel_q;
    if (reg_wr) begin
      case (reg_addr)
        A_OPC:   opc_d  = reg_wdata;
        A_TXN:   txn_d  = reg_wdata;
        A_RXN:   rxn_d  = reg_wdata;
        A_CSEL:  csel_d = reg_wdata[CSW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q  <= '0;
      txn_q  <= '0;
      rxn_q  <= '0;
      csel_q <= '0;
    end else if (reg_wr) begin
      opc_q  <= opc_d;
      txn_q  <= txn_d;
      rxn_q  <= rxn_d;
      csel_q <= csel_d;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (in_buf) begin
      reg_rdata = buf_rdata;
    end else begin
      case (reg_addr)
        A_OPC:   reg_rdata = opc_q;
        A_CMD:   reg_rdata = {7'b0, busy};
        A_STAT:  reg_rdata = {busy, 7'b0};
        A_CSEL:  reg_rdata = 8'(csel_q);
        A_TXN:   reg_rdata = txn_q;
        A_RXN:   reg_rdata = rxn_q;
        default: reg_rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/spi_cmd_buf.sv
module spi_cmd_buf #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] host_addr,
  input  logic          host_we,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [7:0]    eng_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [7:0]    eng_wdata
);

  logic [7:0]    mem [DEPTH];
  logic          we;
  logic [AW-1:0] waddr;
  logic [7:0]    wdata;

  always_comb begin
    we    = eng_we | host_we;
    waddr = eng_we ? eng_waddr : host_addr;
    wdata = eng_we ? eng_wdata : host_wdata;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign host_rdata = mem[host_addr];
  assign eng_rdata  = mem[eng_raddr];

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int DIV    = 4,
  localparam int HALF  = DIV / 2,
  localparam int HCW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);

  logic           act_q, act_d;
  logic           sclk_q, sclk_d;
  logic [HCW-1:0] hcnt_q, hcnt_d;
  logic [2:0]     bcnt_q, bcnt_d;
  logic [7:0]     sh_q, sh_d;
  logic [7:0]     rx_q, rx_d;

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    hcnt_d = hcnt_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    done   = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        sclk_d = 1'b0;
        hcnt_d = '0;
        bcnt_d = '0;
        sh_d   = tx_byte;
      end
    end else if (hcnt_q == HCW'(HALF - 1)) begin
      hcnt_d = '0;
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[6:0], miso};
      end else begin
        sclk_d = 1'b0;
        if (bcnt_q == 3'd7) begin
          act_d = 1'b0;
          done  = 1'b1;
        end else begin
          bcnt_d = bcnt_q + 3'd1;
          sh_d   = {sh_q[6:0], 1'b0};
        end
      end
    end else begin
      hcnt_d = hcnt_q + HCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      hcnt_q <= hcnt_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = act_q & sh_q[7];
  assign rx_byte = rx_q;

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int NCS   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int CSW  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_req,
  input  logic           clr_req,
  input  logic [7:0]     opc,
  input  logic [CSW-1:0] csel,
  input  logic [7:0]     txn,
  input  logic [7:0]     rxn,
  input  logic           sh_done,
  input  logic [7:0]     sh_rx,
  output logic           sh_start,
  output logic [7:0]     sh_tx,
  output logic [AW-1:0]  buf_raddr,
  input  logic [7:0]     buf_rdata,
  output logic           buf_we,
  output logic [AW-1:0]  buf_waddr,
  output logic [7:0]     buf_wdata,
  output logic           busy,
  output logic [PW-1:0]  ptr,
  output logic [NCS-1:0] cs_n
);

  seq_state_t     st_q, st_d;
  logic [PW-1:0]  ptr_q, ptr_d;
  logic [8:0]     left_q, left_d;
  logic [8:0]     rxe_q, rxe_d;
  logic           wait_q, wait_d;
  logic [7:0]     op_q, op_d;
  logic [CSW-1:0] cs_q, cs_d;
  logic [NCS-1:0] csn_q, csn_d;

  logic [PW-1:0]  base, room;
  logic [8:0]     room9, tx9, rx9, txe9, rest9, rxe9;

  always_comb begin
    base  = clr_req ? '0 : ptr_q;
    room  = PW'(DEPTH) - base;
    room9 = 9'(room);
    tx9   = {1'b0, txn};
    rx9   = {1'b0, rxn};
    txe9  = (tx9 > room9) ? room9 : tx9;
    rest9 = room9 - txe9;
    rxe9  = (rx9 > rest9) ? rest9 : rx9;
  end

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    left_d    = left_q;
    rxe_d     = rxe_q;
    wait_d    = wait_q;
    op_d      = op_q;
    cs_d      = cs_q;
    sh_start  = 1'b0;
    sh_tx     = 8'h00;
    buf_we    = 1'b0;
    buf_wdata = sh_rx;
    case (st_q)
      ST_IDLE: begin
        ptr_d = base;
        if (exec_req) begin
          st_d   = ST_OPC;
          op_d   = opc;
          cs_d   = csel;
          left_d = txe9;
          rxe_d  = rxe9;
          wait_d = 1'b0;
        end
      end
      ST_OPC: begin
        if (!wait_q) begin
          sh_start = 1'b1;
          sh_tx    = op_q;
          wait_d   = 1'b1;
        end else if (sh_done) begin
          wait_d = 1'b0;
          if (left_q != 9'd0) begin
            st_d = ST_TX;
          end else if (rxe_q != 9'd0) begin
            st_d   = ST_RX;
            left_d = rxe_q;
          end else begin
            st_d = ST_FIN;
          end
        end
      end
      ST_TX: begin
        if (!wait_q) begin
          sh_start = 1'b1;
          sh_tx    = buf_rdata;
          wait_d   = 1'b1;
        end else if (sh_done) begin
          wait_d = 1'b0;
          ptr_d  = ptr_q + PW'(1);
          left_d = left_q - 9'd1;
          if (left_q == 9'd1) begin
            if (rxe_q != 9'd0) begin
              st_d   = ST_RX;
              left_d = rxe_q;
            end else begin
              st_d = ST_FIN;
            end
          end
        end
      end
      ST_RX: begin
        if (!wait_q) begin
          sh_start = 1'b1;
          sh_tx    = 8'h00;
          wait_d   = 1'b1;
        end else if (sh_done) begin
          wait_d = 1'b0;
          buf_we = 1'b1;
          ptr_d  = ptr_q + PW'(1);
          left_d = left_q - 9'd1;
          if (left_q == 9'd1) st_d = ST_FIN;
        end
      end
      ST_FIN: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    csn_d = '1;
    if (st_d == ST_OPC || st_d == ST_TX || st_d == ST_RX) begin
      csn_d = ~(NCS'(1) << cs_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      left_q <= '0;
      rxe_q  <= '0;
      wait_q <= 1'b0;
      op_q   <= '0;
      cs_q   <= '0;
      csn_q  <= '1;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      left_q <= left_d;
      rxe_q  <= rxe_d;
      wait_q <= wait_d;
      op_q   <= op_d;
      cs_q   <= cs_d;
      csn_q  <= csn_d;
    end
  end

  assign buf_raddr = ptr_q[AW-1:0];
  assign buf_waddr = ptr_q[AW-1:0];
  assign busy      = (st_q != ST_IDLE);
  assign ptr       = ptr_q;
  assign cs_n      = csn_q;

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int DEPTH = 64,
  parameter int DIV   = 4,
  parameter int NCS   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int CSW  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     reg_addr,
  input  logic           reg_wr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           spi_sclk,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs_n
);

  logic [1:0]     rs_q;
  logic           rst_i;
  logic           eng_busy;
  logic [7:0]     opc, txn, rxn;
  logic [CSW-1:0] csel;
  logic           exec_req, clr_req;
  logic [AW-1:0]  host_addr;
  logic           host_we;
  logic [7:0]     host_rdata;
  logic [AW-1:0]  eng_raddr, eng_waddr;
  logic [7:0]     eng_rdata, eng_wdata;
  logic           eng_we;
  logic [PW-1:0]  eng_ptr;
  logic           sh_start, sh_done;
  logic [7:0]     sh_tx, sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  spi_cmd_regs #(.DEPTH(DEPTH), .NCS(NCS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (eng_busy),
    .buf_rdata (host_rdata),
    .buf_addr  (host_addr),
    .buf_we    (host_we),
    .opc_q     (opc),
    .csel_q    (csel),
    .txn_q     (txn),
    .rxn_q     (rxn),
    .exec_req  (exec_req),
    .clr_req   (clr_req)
  );

  spi_cmd_buf #(.DEPTH(DEPTH)) u_buf (
    .clk        (clk),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_wdata (reg_wdata),
    .host_rdata (host_rdata),
    .eng_raddr  (eng_raddr),
    .eng_rdata  (eng_rdata),
    .eng_we     (eng_we),
    .eng_waddr  (eng_waddr),
    .eng_wdata  (eng_wdata)
  );

  spi_cmd_seq #(.DEPTH(DEPTH), .NCS(NCS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i),
    .exec_req  (exec_req),
    .clr_req   (clr_req),
    .opc       (opc),
    .csel      (csel),
    .txn       (txn),
    .rxn       (rxn),
    .sh_done   (sh_done),
    .sh_rx     (sh_rx),
    .sh_start  (sh_start),
    .sh_tx     (sh_tx),
    .buf_raddr (eng_raddr),
    .buf_rdata (eng_rdata),
    .buf_we    (eng_we),
    .buf_waddr (eng_waddr),
    .buf_wdata (eng_wdata),
    .busy      (eng_busy),
    .ptr       (eng_ptr),
    .cs_n      (spi_cs_n)
  );

  spi_cmd_shift #(.DIV(DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_i),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk #(
  parameter int DEPTH = 64,
  parameter int NCS   = 4,
  parameter int PW    = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] spi_cs_n,
  input logic           spi_sclk,
  input logic           spi_mosi,
  input logic           eng_busy,
  input logic           eng_we,
  input logic [PW-1:0]  eng_ptr
);

  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> ((&spi_cs_n) && !spi_sclk));

  // R2
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(spi_sclk) |-> !(&$past(spi_cs_n)));

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R8
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (32'(eng_ptr) < DEPTH));

  // R4
  cs_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&spi_cs_n) && !(&$past(spi_cs_n))) |-> $stable(spi_cs_n));

endmodule

bind spi_cmd_engine spi_cmd_chk #(.DEPTH(DEPTH), .NCS(NCS), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .eng_busy (eng_busy),
  .eng_we   (eng_we),
  .eng_ptr  (eng_ptr)
);

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;

  localparam int DEPTH = 64;
  localparam int DIV   = 4;
  localparam int NCS   = 4;

  logic           clk;
  logic           rst_n;
  logic [7:0]     reg_addr;
  logic           reg_wr;
  logic [7:0]     reg_wdata;
  logic [7:0]     reg_rdata;
  logic           spi_sclk;
  logic           spi_mosi;
  logic           spi_miso;
  logic [NCS-1:0] spi_cs_n;

  spi_cmd_engine #(.DEPTH(DEPTH), .DIV(DIV), .NCS(NCS)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso),
    .spi_cs_n  (spi_cs_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q [$];
  logic [7:0] model [DEPTH];
  int mptr = 0;
  logic [NCS-1:0] exp_cs = '1;
  int frames = 0;
  int s_bit = 0;
  int s_byte = 0;
  logic [7:0] m_sh = 8'h00;

  function automatic logic [7:0] resp(input int k);
    return 8'((k * 29 + 53) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Slave model: frame start
  wire all_hi = &spi_cs_n;
  always @(negedge all_hi) begin
    logic [7:0] r;
    frames++;
    s_bit  = 0;
    s_byte = 0;
    r = resp(0);
    spi_miso = r[7];
  end

  // Monitor: capture mosi, compare against scoreboard queue
  always @(posedge spi_sclk) begin
    if (!all_hi) begin
      m_sh = {m_sh[6:0], spi_mosi};
      n_cmp++;
      if (spi_cs_n !== exp_cs) begin
        n_bad++;
        $display("FAIL R4: cs_n actual %0h expected %0h", spi_cs_n, exp_cs);
      end
      s_bit++;
      if (s_bit == 8) begin
        s_bit = 0;
        s_byte++;
        if (exp_q.size() == 0) begin
          n_cmp++;
          n_bad++;
          $display("FAIL R6: unexpected byte actual %0h expected none", m_sh);
        end else begin
          chk("R2/R3 mosi byte", 32'(m_sh), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  always @(negedge spi_sclk) begin
    logic [7:0] r;
    r = resp(s_byte);
    spi_miso = r[7 - s_bit];
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic fill(input int idx, input logic [7:0] v);
    wr(8'(8'h80 + idx), v);
    model[idx] = v;
  endtask

  task automatic run_cmd(input logic [7:0] op, input int txn, input int rxn,
                         input int csn, input bit clr, input bit dbl);
    int base, room, txe, rxe, fr0;
    logic [7:0] d;
    wr(8'h00, op);
    wr(8'h48, 8'(txn));
    wr(8'h4B, 8'(rxn));
    wr(8'h1D, 8'(csn));
    base = clr ? 0 : mptr;
    room = DEPTH - base;
    txe  = (txn > room) ? room : txn;
    rxe  = (rxn > room - txe) ? room - txe : rxn;
    exp_q.push_back(op);
    for (int i = 0; i < txe; i++) exp_q.push_back(model[base + i]);
    for (int i = 0; i < rxe; i++) exp_q.push_back(8'h00);
    for (int i = 0; i < rxe; i++) model[base + txe + i] = resp(1 + txe + i);
    mptr   = base + txe + rxe;
    exp_cs = ~(NCS'(1) << csn);
    fr0    = frames;
    wr(8'h02, clr ? 8'h11 : 8'h01);
    reg_addr = 8'h03;
    #1;
    chk("R5 busy one cycle after execute", 32'(reg_rdata[7]), 32'd1);
    chk("R4 cs low one cycle after execute", 32'(spi_cs_n), 32'(exp_cs));
    if (dbl) begin
      repeat (40) @(negedge clk);
      wr(8'h00, 8'hEE);
      wr(8'h02, 8'h01);
    end
    do rd(8'h03, d); while (d[7]);
    repeat (2) @(negedge clk);
    chk("R4 cs released", 32'(spi_cs_n), 32'(NCS'('1)));
    chk("R2 all frame bytes seen", 32'(exp_q.size()), 32'd0);
    chk("R6 one frame per execute", 32'(frames), 32'(fr0 + 1));
    for (int i = 0; i < rxe; i++) begin
      rd(8'(8'h80 + base + txe + i), d);
      chk("R3 rx byte placement", 32'(d), 32'(model[base + txe + i]));
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    rst_n     = 1'b0;
    reg_addr  = 8'h00;
    reg_wr    = 1'b0;
    reg_wdata = 8'h00;
    spi_miso  = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h03, d); chk("R1 busy after reset", 32'(d), 32'h0);
    chk("R1 cs_n after reset", 32'(spi_cs_n), 32'(NCS'('1)));
    chk("R1 sclk low", 32'(spi_sclk), 32'd0);
    chk("R1 mosi low", 32'(spi_mosi), 32'd0);
    rd(8'h00, d); chk("R1 opcode reg", 32'(d), 32'h0);
    rd(8'h48, d); chk("R1 tx count reg", 32'(d), 32'h0);
    rd(8'h4B, d); chk("R1 rx count reg", 32'(d), 32'h0);
    rd(8'h1D, d); chk("R1 cs reg", 32'(d), 32'h0);

    for (int i = 0; i < DEPTH; i++) fill(i, 8'((i * 37 + 11) & 255));

    // R9 read-back
    wr(8'h00, 8'h3C); rd(8'h00, d); chk("R9 opcode readback", 32'(d), 32'h3C);
    wr(8'h48, 8'h07); rd(8'h48, d); chk("R9 tx readback", 32'(d), 32'h07);
    wr(8'h4B, 8'h09); rd(8'h4B, d); chk("R9 rx readback", 32'(d), 32'h09);
    wr(8'h1D, 8'h03); rd(8'h1D, d); chk("R9 cs readback", 32'(d), 32'h03);
    rd(8'h85, d); chk("R9 buffer readback", 32'(d), 32'(model[5]));

    // R3 R4 read-only command on line 2
    run_cmd(8'h9F, 0, 3, 2, 1'b1, 1'b0);
    // R2 write-only command on line 0
    run_cmd(8'h02, 4, 0, 0, 1'b1, 1'b0);
    // R2 R3 mixed on line 1
    run_cmd(8'h0B, 3, 2, 1, 1'b1, 1'b0);
    // R7 continue from pointer 5 without clear
    fill(5, 8'h5A);
    run_cmd(8'h05, 1, 1, 3, 1'b0, 1'b0);
    // R7 clear restarts at index 0
    run_cmd(8'h06, 1, 0, 0, 1'b1, 1'b0);
    // R6 execute while busy ignored
    run_cmd(8'hAB, 2, 2, 1, 1'b1, 1'b1);
    // R10 opcode only
    run_cmd(8'h04, 0, 0, 2, 1'b1, 1'b0);
    // R8 clamp: 60 tx, 10 rx requested, 4 rx fit
    run_cmd(8'h3B, 60, 10, 3, 1'b1, 1'b0);
    // R8 R10 no room left: opcode only, no wrap
    run_cmd(8'h03, 2, 2, 0, 1'b0, 1'b0);
    rd(8'h80, d); chk("R8 no wrap into index 0", 32'(d), 32'(model[0]));
    rd(8'hBF, d); chk("R8 last index holds rx", 32'(d), 32'(model[63]));

    finish_run();
  end

endmodule